// File: doc/BRIEF.md
# Clock Recovery Bandwidth Acquisition Sequencer

This block schedules the loop bandwidth that a bit-clock recovery loop should use while it locks onto a new transmission and after it has locked. An acquisition request sets the bandwidth to wide so that the timing estimate can move quickly. After the wide stage, the block drops to medium for a fixed number of bit periods to cut jitter. It then hands the loop back to a residual setting chosen by the host. The residual may be wide, medium, narrow or a freeze that holds the estimate through short fades.

The wide stage ends in one of two ways. When a frame-sync search is armed early in the stage, wide is kept until the frame-sync detector fires, however long that takes. When no search is armed in that window, wide lasts a fixed number of bits. All durations are counted in bit strobes from the recovered clock, not in system clock cycles.

The block contains no phase detector, no loop filter and no oscillator. It only produces the bandwidth code and phase state that such a loop consumes.

Top module: `bw_acq_seq`

## Requirements
- R1: A high acq_start_i on a clock edge puts the block into the timed wide phase (phase_o = 1) with busy_o = 1 and bw_o = 2'b00 (wide) from the next cycle. This happens whatever phase the block was in, and the strobe count restarts.
- R2: In the timed wide phase with no search armed, the phase lasts exactly 16 counted bit strobes. The 16th strobe moves the block to the medium phase (phase_o = 3, bw_o = 2'b01).
- R3: If search_armed_i is high while fewer than 14 strobes have been counted in the timed wide phase, the block enters the sync-wait wide phase (phase_o = 2, bw_o = 2'b00). It stays there, whatever the number of strobes, until sync_det_i, which moves it to medium.
- R4: search_armed_i seen after 14 or more strobes of the timed wide phase has no effect. The phase still ends on the 16th strobe.
- R5: The medium phase lasts exactly 30 counted bit strobes. The block then returns to idle (phase_o = 0, busy_o = 0).
- R6: After reset and in idle, bw_o equals residual_i (00 wide, 01 medium, 10 narrow, 11 hold), busy_o = 0 and phase_o = 0.
- R7: sync_det_i has no effect outside the sync-wait phase.
- R8: While hold_i is high, bw_o = 2'b11 (hold) and bit strobes are not counted. The sequence resumes from the same count when hold_i falls.
- R9: Clock cycles without bit_stb_i never advance any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_stb_i | input | 1 | One-cycle pulse per received bit period |
| acq_start_i | input | 1 | Acquisition request; restarts the sequence |
| search_armed_i | input | 1 | Frame-sync search is armed |
| sync_det_i | input | 1 | Frame-sync detected pulse |
| residual_i | input | 2 | Bandwidth used after the sequence ends |
| hold_i | input | 1 | Forces hold output and pauses counting |
| bw_o | output | 2 | Bandwidth code: 00 wide, 01 medium, 10 narrow, 11 hold |
| busy_o | output | 1 | Sequence in progress |
| phase_o | output | 2 | 0 idle, 1 timed wide, 2 sync-wait wide, 3 medium |

## Verification
The bench probes each phase boundary one strobe early and exactly on the boundary. An off-by-one counter would leave wide or medium a strobe too soon or too late. Arming is tried at 5 and at 14 strobes, which catches a window compare that is inclusive where it should be strict. Sync pulses are sent in idle and in medium, where a leaky decoder would cut the medium phase short. A restart in the middle of medium, and hold pulses that arrive with strobes, expose a count that fails to clear or keeps running while frozen.

// File: rtl/bw_seq_pkg.sv
package bw_seq_pkg;
  typedef enum logic [1:0] {
    BW_WIDE   = 2'b00,
    BW_MED    = 2'b01,
    BW_NARROW = 2'b10,
    BW_HOLD   = 2'b11
  } bw_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WIDE_T = 2'd1,
    PH_WIDE_S = 2'd2,
    PH_MED    = 2'd3
  } phase_e;
endpackage

// File: rtl/bw_bit_counter.sv
module bw_bit_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bw_phase_fsm.sv
module bw_phase_fsm
  import bw_seq_pkg::*;
#(
  parameter int unsigned WIDE_BITS = 16,
  parameter int unsigned ARM_WIN   = 14,
  parameter int unsigned MED_BITS  = 30,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             acq_start_i,
  input  logic             search_armed_i,
  input  logic             sync_det_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output phase_e           phase_o
);
  localparam logic [CNT_W-1:0] WideLast = CNT_W'(WIDE_BITS - 1);
  localparam logic [CNT_W-1:0] MedLast  = CNT_W'(MED_BITS - 1);
  localparam logic [CNT_W-1:0] ArmLim   = CNT_W'(ARM_WIN);

  phase_e phase_q, phase_d;
  logic   counting;

  assign counting = (phase_q == PH_WIDE_T) || (phase_q == PH_MED);
  assign cnt_en_o = counting && bit_stb_i && !hold_i;

  always_comb begin
    phase_d   = phase_q;
    cnt_clr_o = 1'b0;
    if (acq_start_i) begin
      phase_d   = PH_WIDE_T;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (phase_q)
        PH_WIDE_T: begin
          if (search_armed_i && (cnt_i < ArmLim)) begin
            phase_d   = PH_WIDE_S;
            cnt_clr_o = 1'b1;
          end else if (cnt_en_o && (cnt_i == WideLast)) begin
            phase_d   = PH_MED;
            cnt_clr_o = 1'b1;
          end
        end
        PH_WIDE_S: begin
          if (sync_det_i) begin
            phase_d   = PH_MED;
            cnt_clr_o = 1'b1;
          end
        end
        PH_MED: begin
          if (cnt_en_o && (cnt_i == MedLast)) begin
            phase_d   = PH_IDLE;
            cnt_clr_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bw_out_sel.sv
module bw_out_sel
  import bw_seq_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [1:0] residual_i,
  input  logic       hold_i,
  output bw_e        bw_o,
  output logic       busy_o
);
  always_comb begin
    unique case (phase_i)
      PH_WIDE_T, PH_WIDE_S: bw_o = BW_WIDE;
      PH_MED:               bw_o = BW_MED;
      default:              bw_o = bw_e'(residual_i);
    endcase
    if (hold_i) bw_o = BW_HOLD;
  end
  assign busy_o = (phase_i != PH_IDLE);
endmodule

// File: rtl/bw_acq_seq.sv
module bw_acq_seq
  import bw_seq_pkg::*;
#(
  parameter int unsigned WIDE_BITS = 16,
  parameter int unsigned ARM_WIN   = 14,
  parameter int unsigned MED_BITS  = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_stb_i,
  input  logic       acq_start_i,
  input  logic       search_armed_i,
  input  logic       sync_det_i,
  input  logic [1:0] residual_i,
  input  logic       hold_i,
  output logic [1:0] bw_o,
  output logic       busy_o,
  output logic [1:0] phase_o
);
  localparam int unsigned MaxBits = (WIDE_BITS > MED_BITS) ? WIDE_BITS : MED_BITS;
  localparam int unsigned CntW    = $clog2(MaxBits + 1);

  logic [CntW-1:0] cnt;
  logic            cnt_clr, cnt_en;
  phase_e          phase;
  bw_e             bw;

  bw_bit_counter #(.CNT_W(CntW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .cnt_o  (cnt)
  );

  bw_phase_fsm #(
    .WIDE_BITS (WIDE_BITS),
    .ARM_WIN   (ARM_WIN),
    .MED_BITS  (MED_BITS),
    .CNT_W     (CntW)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_stb_i      (bit_stb_i),
    .acq_start_i    (acq_start_i),
    .search_armed_i (search_armed_i),
    .sync_det_i     (sync_det_i),
    .hold_i         (hold_i),
    .cnt_i          (cnt),
    .cnt_clr_o      (cnt_clr),
    .cnt_en_o       (cnt_en),
    .phase_o        (phase)
  );

  bw_out_sel u_sel (
    .phase_i    (phase),
    .residual_i (residual_i),
    .hold_i     (hold_i),
    .bw_o       (bw),
    .busy_o     (busy_o)
  );

  assign bw_o    = bw;
  assign phase_o = phase;
endmodule

// File: rtl/bw_acq_seq_chk.sv
module bw_acq_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_stb_i,
  input logic       acq_start_i,
  input logic       search_armed_i,
  input logic       sync_det_i,
  input logic [1:0] residual_i,
  input logic       hold_i,
  input logic [1:0] bw_o,
  input logic       busy_o,
  input logic [1:0] phase_o
);
  p_start_wide_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_i |=> (phase_o == 2'd1) && busy_o && (hold_i || bw_o == 2'b00));

  p_sync_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && sync_det_i && !acq_start_i) |=> phase_o == 2'd3);

  p_idle_residual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0 && !hold_i) |-> (bw_o == residual_i) && !busy_o);

  p_sync_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd2 && sync_det_i && !acq_start_i && !bit_stb_i && !search_armed_i)
      |=> $stable(phase_o));

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> bw_o == 2'b11);

  p_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_stb_i && !acq_start_i && !search_armed_i && !sync_det_i) |=> $stable(phase_o));
endmodule

bind bw_acq_seq bw_acq_seq_chk u_chk (.*);

// File: tb/tb_bw_acq_seq.sv
`timescale 1ns/1ps
module tb_bw_acq_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_stb_i = 1'b0;
  logic       acq_start_i = 1'b0;
  logic       search_armed_i = 1'b0;
  logic       sync_det_i = 1'b0;
  logic [1:0] residual_i = 2'b10;
  logic       hold_i = 1'b0;
  logic [1:0] bw_o;
  logic       busy_o;
  logic [1:0] phase_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bw_acq_seq dut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      bit_stb_i = 1'b1; cyc(); bit_stb_i = 1'b0; cyc();
    end
  endtask

  task automatic start();
    acq_start_i = 1'b1; cyc(); acq_start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 reset phase", {2'b0, phase_o}, 4'd0);
    chk("R6 reset busy", {3'b0, busy_o}, 4'd0);
    for (int r = 0; r < 4; r++) begin
      residual_i = 2'(r); #1;
      chk("R6 idle residual", {2'b0, bw_o}, 4'(r));
    end
    residual_i = 2'b10;
    strobes(3);
    chk("R9 strobes in idle", {2'b0, phase_o}, 4'd0);
  endtask

  task automatic t_timed();
    start();
    chk("R1 wide phase", {2'b0, phase_o}, 4'd1);
    chk("R1 wide bw", {2'b0, bw_o}, 4'd0);
    chk("R1 busy", {3'b0, busy_o}, 4'd1);
    repeat (40) cyc();
    chk("R9 no strobe no advance", {2'b0, phase_o}, 4'd1);
    strobes(15);
    chk("R2 still wide at 15", {2'b0, phase_o}, 4'd1);
    strobes(1);
    chk("R2 medium at 16", {2'b0, phase_o}, 4'd3);
    chk("R2 medium bw", {2'b0, bw_o}, 4'd1);
    strobes(29);
    chk("R5 still medium at 29", {2'b0, phase_o}, 4'd3);
    strobes(1);
    chk("R5 idle at 30", {2'b0, phase_o}, 4'd0);
    chk("R5 busy low", {3'b0, busy_o}, 4'd0);
    chk("R6 residual after sequence", {2'b0, bw_o}, 4'd2);
  endtask

  task automatic t_armed();
    start();
    strobes(5);
    search_armed_i = 1'b1; cyc(); search_armed_i = 1'b0;
    chk("R3 sync-wait phase", {2'b0, phase_o}, 4'd2);
    strobes(40);
    chk("R3 wide held past 16", {2'b0, phase_o}, 4'd2);
    chk("R3 wide bw", {2'b0, bw_o}, 4'd0);
    sync_det_i = 1'b1; cyc(); sync_det_i = 1'b0;
    chk("R3 medium after sync", {2'b0, phase_o}, 4'd3);
    strobes(29);
    chk("R5 medium 29 after sync", {2'b0, phase_o}, 4'd3);
    strobes(1);
    chk("R5 idle after sync path", {2'b0, phase_o}, 4'd0);
  endtask

  task automatic t_late_arm();
    start();
    strobes(14);
    search_armed_i = 1'b1; cyc();
    chk("R4 late arm ignored", {2'b0, phase_o}, 4'd1);
    strobes(1);
    chk("R4 still wide at 15", {2'b0, phase_o}, 4'd1);
    strobes(1);
    search_armed_i = 1'b0;
    chk("R4 medium at 16", {2'b0, phase_o}, 4'd3);
    strobes(30);
    chk("R5 idle after late arm", {2'b0, phase_o}, 4'd0);
  endtask

  task automatic t_sync_ignored();
    sync_det_i = 1'b1; cyc(); sync_det_i = 1'b0;
    chk("R7 sync in idle", {2'b0, phase_o}, 4'd0);
    start();
    sync_det_i = 1'b1; cyc(); sync_det_i = 1'b0;
    chk("R7 sync in timed wide", {2'b0, phase_o}, 4'd1);
    strobes(16);
    strobes(10);
    sync_det_i = 1'b1; cyc(); sync_det_i = 1'b0;
    strobes(19);
    chk("R7 sync in medium ignored", {2'b0, phase_o}, 4'd3);
    strobes(1);
    chk("R7 medium ends on 30", {2'b0, phase_o}, 4'd0);
  endtask

  task automatic t_restart();
    start();
    strobes(16);
    strobes(10);
    start();
    chk("R1 restart from medium", {2'b0, phase_o}, 4'd1);
    strobes(15);
    chk("R1 count cleared", {2'b0, phase_o}, 4'd1);
    strobes(1);
    chk("R1 medium after restart", {2'b0, phase_o}, 4'd3);
    strobes(30);
  endtask

  task automatic t_hold();
    residual_i = 2'b01;
    hold_i = 1'b1; #1;
    chk("R8 hold in idle", {2'b0, bw_o}, 4'd3);
    hold_i = 1'b0;
    start();
    strobes(10);
    hold_i = 1'b1;
    strobes(10);
    chk("R8 hold output", {2'b0, bw_o}, 4'd3);
    hold_i = 1'b0;
    strobes(5);
    chk("R8 count paused", {2'b0, phase_o}, 4'd1);
    strobes(1);
    chk("R8 resumes to medium", {2'b0, phase_o}, 4'd3);
    strobes(30);
    chk("R8 residual after hold run", {2'b0, bw_o}, 4'd1);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_timed();
    t_armed();
    t_late_arm();
    t_sync_ignored();
    t_restart();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule